// File: doc/BRIEF.md
# Centisecond Stopwatch Counter

This block keeps a two-digit decimal stopwatch value in tenths and hundredths of a second. It is driven by a single system clock and a slow time-base pulse. The pulse arrives as a one-cycle enable, 512 times per second. A fractional divider turns those pulses into exactly 100 ticks per second. Each tick advances a BCD hundredths digit. The carry from that digit advances a BCD tenths digit and raises a sticky 10 Hz interrupt request.

Software reaches the block over a small register bus. The bus has a 2-bit address, read and write strobes, and 4-bit data. The registers are:

- Address 0: hundredths (read returns the held copy).
- Address 1: tenths.
- Address 2: control, with the run-enable bit at bit 0.
- Address 3: interrupt request, with the flag at bit 3.

Reading the tenths digit snapshots the hundredths digit into a holding register, so a following read of address 0 returns a digit pair that belongs together. Any write to either digit address clears the count, whatever the data.

Top module: `csec_stopwatch`

## Requirements
- R1: Counting advances only while control bit 0 (address 2) is 1; that bit reads back at bit 0 of address 2. Clearing it freezes both digits and the divider phase without resetting them.
- R2: Counting runs only on time-base pulses taken while enabled. The k-th tick after a clear falls on the enabled pulse numbered ceil(512·k/100), so the first tick falls on the 6th pulse. In any 512 such pulses there are 88 gaps of 5 pulses and 12 gaps of 6.
- R3: Both digits are BCD and always hold a value from 0 to 9.
- R4: Each tick increments the hundredths digit. Going from 9 to 0 increments the tenths digit (address 1). The tenths digit wraps from 9 to 0 with no further effect.
- R5: A write to address 0 or 1 clears both digits, the hundredths holding register and the divider phase, whatever the write data.
- R6: A read of address 1 returns the tenths digit and copies the live hundredths digit into the holding register at that clock edge. A read of address 0 returns the holding register.
- R7: Each hundredths carry sets the interrupt flag. The flag reads at bit 3 of address 3 and drives the irq_req port.
- R8: The flag stays set until a write to address 3 with bit 3 equal to 0. A write with bit 3 equal to 1 leaves it set. If a carry and a clearing write fall in the same cycle, the flag ends up set.
- R9: After reset, every register reads 0 and irq_req is 0. bus_rdata is 0 whenever bus_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tb_pulse | input | 1 | One-cycle 512 Hz time-base enable |
| bus_addr | input | 2 | Register address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 4 | Write data |
| bus_rdata | output | 4 | Read data, valid while bus_rd is high |
| irq_req | output | 1 | Sticky 10 Hz interrupt request flag |

## Verification
The bench checks the digit pair after every pulse of a full 512-pulse period. It also tallies the observed gaps between ticks, so a divider that drifts, or that bunches its long periods together, shows up as a wrong count or a wrong 5/6 split. It pauses the count partway through a divider period and resumes it. A design that reset the phase on disable would tick one pulse late or early. It clears the count in the middle of a phase, so a clear that left the accumulator alone would shift the next tick. It reads the hundredths digit after the count has moved on from a tenths read, which exposes a live read in place of the held copy. It also lines a carry up with a flag-clearing write in the same cycle; a design where the write wins would drop that interrupt.

// File: rtl/csw_pkg.sv
`timescale 1ns/1ps
package csw_pkg;

    localparam int DIGIT_W    = 4;
    localparam int DATA_W     = 4;
    localparam int ADDR_W     = 2;
    localparam int NUM_DIGITS = 2;
    localparam int DIGIT_MAX  = 9;
    localparam int EN_BIT     = 0;
    localparam int IRQ_BIT    = 3;

    typedef logic [DIGIT_W-1:0] digit_t;
    typedef logic [DATA_W-1:0]  word_t;

    typedef enum logic [ADDR_W-1:0] {
        SEL_HUND  = 2'd0,
        SEL_TENTH = 2'd1,
        SEL_CTRL  = 2'd2,
        SEL_IRQ   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     rd;
        logic     wr;
        reg_sel_e sel;
        word_t    wdata;
    } bus_req_t;

    typedef struct packed {
        logic run;
        logic clr;
    } ctrl_t;

    function automatic digit_t digit_next(digit_t cur, digit_t top);
        return (cur >= top) ? '0 : digit_t'(cur + digit_t'(1));
    endfunction

    function automatic logic is_digit_sel(reg_sel_e s);
        return (s == SEL_HUND) || (s == SEL_TENTH);
    endfunction

endpackage

// File: rtl/csw_frac_div.sv
`timescale 1ns/1ps
module csw_frac_div #(
    parameter int BASE_HZ = 512,
    parameter int OUT_HZ  = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    input  logic pulse,
    output logic tick
);

    localparam int ACC_W = $clog2(BASE_HZ + OUT_HZ);
    localparam logic [ACC_W-1:0] STEP  = ACC_W'(OUT_HZ);
    localparam logic [ACC_W-1:0] LIMIT = ACC_W'(BASE_HZ);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_sum;
    logic             wrap;
    logic             advance;

    assign acc_sum = acc_q + STEP;
    assign wrap    = (acc_sum >= LIMIT);
    assign advance = run & pulse & ~clr;
    assign tick    = advance & wrap;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc_q <= '0;
        end else if (advance) begin
            acc_q <= wrap ? (acc_sum - LIMIT) : acc_sum;
        end
    end

endmodule

// File: rtl/csw_bcd_digit.sv
`timescale 1ns/1ps
module csw_bcd_digit
    import csw_pkg::*;
#(
    parameter int TOP = DIGIT_MAX
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   clr,
    input  logic   inc,
    output digit_t value,
    output logic   carry
);

    localparam digit_t TOP_V = DIGIT_W'(TOP);

    digit_t val_q;

    assign value = val_q;
    assign carry = inc & (val_q == TOP_V);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            val_q <= '0;
        end else if (inc) begin
            val_q <= digit_next(val_q, TOP_V);
        end
    end

endmodule

// File: rtl/csw_regfile.sv
`timescale 1ns/1ps
module csw_regfile
    import csw_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_req_t req,
    input  digit_t   hund,
    input  digit_t   tenth,
    input  logic     lo_carry,
    output ctrl_t    ctl,
    output word_t    rdata,
    output logic     irq
);

    logic   en_q;
    digit_t hold_q;
    logic   irq_q;
    logic   wr_ctrl;
    logic   wr_irq;
    logic   rd_tenth;
    logic   irq_drop;
    logic   unused_wdata_bits;

    assign wr_ctrl  = req.wr & (req.sel == SEL_CTRL);
    assign wr_irq   = req.wr & (req.sel == SEL_IRQ);
    assign rd_tenth = req.rd & (req.sel == SEL_TENTH);
    assign irq_drop = wr_irq & ~req.wdata[IRQ_BIT];

    assign ctl.run = en_q;
    assign ctl.clr = req.wr & is_digit_sel(req.sel);
    assign irq     = irq_q;

    assign unused_wdata_bits = ^req.wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= 1'b0;
        end else if (wr_ctrl) begin
            en_q <= req.wdata[EN_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || ctl.clr) begin
            hold_q <= '0;
        end else if (rd_tenth) begin
            hold_q <= hund;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
        end else if (lo_carry) begin
            irq_q <= 1'b1;
        end else if (irq_drop) begin
            irq_q <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        if (req.rd) begin
            unique case (req.sel)
                SEL_HUND:  rdata = word_t'(hold_q);
                SEL_TENTH: rdata = word_t'(tenth);
                SEL_CTRL:  rdata[EN_BIT] = en_q;
                SEL_IRQ:   rdata[IRQ_BIT] = irq_q;
                default:   rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/csec_stopwatch.sv
`timescale 1ns/1ps
module csec_stopwatch
    import csw_pkg::*;
#(
    parameter int BASE_HZ = 512,
    parameter int OUT_HZ  = 100
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tb_pulse,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_rd,
    input  logic                  bus_wr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic                  irq_req
);

    bus_req_t              req;
    ctrl_t                 ctl;
    logic                  tick_100;
    digit_t                digit_val [NUM_DIGITS];
    logic [NUM_DIGITS-1:0] dig_inc;
    logic [NUM_DIGITS-1:0] carry_vec;
    logic                  lo_carry;
    logic                  full_wrap;

    assign req.rd    = bus_rd;
    assign req.wr    = bus_wr;
    assign req.sel   = reg_sel_e'(bus_addr);
    assign req.wdata = bus_wdata;

    csw_frac_div #(
        .BASE_HZ (BASE_HZ),
        .OUT_HZ  (OUT_HZ)
    ) u_div (
        .clk   (clk),
        .rst   (rst),
        .clr   (ctl.clr),
        .run   (ctl.run),
        .pulse (tb_pulse),
        .tick  (tick_100)
    );

    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
        if (g == 0) begin : g_first
            assign dig_inc[g] = tick_100;
        end else begin : g_chain
            assign dig_inc[g] = carry_vec[g-1];
        end

        csw_bcd_digit #(
            .TOP (DIGIT_MAX)
        ) u_dig (
            .clk   (clk),
            .rst   (rst),
            .clr   (ctl.clr),
            .inc   (dig_inc[g]),
            .value (digit_val[g]),
            .carry (carry_vec[g])
        );
    end

    assign lo_carry  = carry_vec[0];
    assign full_wrap = carry_vec[NUM_DIGITS-1];

    csw_regfile u_regs (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .hund     (digit_val[0]),
        .tenth    (digit_val[NUM_DIGITS-1]),
        .lo_carry (lo_carry),
        .ctl      (ctl),
        .rdata    (bus_rdata),
        .irq      (irq_req)
    );

endmodule

// File: rtl/csw_checker.sv
`timescale 1ns/1ps
module csw_checker (
    input logic       clk,
    input logic       rst,
    input logic       run,
    input logic       clr,
    input logic       pulse,
    input logic       tick,
    input logic [3:0] hund,
    input logic [3:0] tenth,
    input logic       irq,
    input logic       full_wrap,
    input logic       bus_wr,
    input logic [1:0] bus_addr,
    input logic [3:0] bus_wdata
);

    logic [7:0] gap_q;
    logic       irq_clear_wr;

    assign irq_clear_wr = bus_wr && (bus_addr == 2'd3) && !bus_wdata[3];

    always_ff @(posedge clk) begin
        if (rst || clr || tick) begin
            gap_q <= '0;
        end else if (run && pulse && gap_q != 8'hFF) begin
            gap_q <= gap_q + 8'd1;
        end
    end

    a_r1_tick_needs_run: assert property (@(posedge clk) disable iff (rst)
        tick |-> (run && pulse));

    a_r1_hold_when_stopped: assert property (@(posedge clk) disable iff (rst)
        (!run && !clr) |=> ($stable(hund) && $stable(tenth)));

    a_r2_gap_five_or_six: assert property (@(posedge clk) disable iff (rst)
        tick |-> (gap_q == 8'd4 || gap_q == 8'd5));

    a_r2_no_long_gap: assert property (@(posedge clk) disable iff (rst)
        (run && pulse && !clr) |-> (tick || gap_q < 8'd5));

    a_r3_bcd_range: assert property (@(posedge clk) disable iff (rst)
        (hund <= 4'd9) && (tenth <= 4'd9));

    a_r4_step: assert property (@(posedge clk) disable iff (rst)
        (tick && hund != 4'd9) |=> (hund == $past(hund) + 4'd1) && $stable(tenth));

    a_r4_carry_chain: assert property (@(posedge clk) disable iff (rst)
        (tick && hund == 4'd9) |=>
            (hund == 4'd0) &&
            (tenth == (($past(tenth) == 4'd9) ? 4'd0 : $past(tenth) + 4'd1)));

    a_r4_silent_wrap: assert property (@(posedge clk) disable iff (rst)
        full_wrap |=> (hund == 4'd0 && tenth == 4'd0));

    a_r5_clear: assert property (@(posedge clk) disable iff (rst)
        clr |=> (hund == 4'd0 && tenth == 4'd0));

    a_r7_irq_set: assert property (@(posedge clk) disable iff (rst)
        (tick && hund == 4'd9) |=> irq);

    a_r8_irq_sticky: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_clear_wr) |=> irq);

endmodule

bind csec_stopwatch csw_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .run       (ctl.run),
    .clr       (ctl.clr),
    .pulse     (tb_pulse),
    .tick      (tick_100),
    .hund      (digit_val[0]),
    .tenth     (digit_val[1]),
    .irq       (irq_req),
    .full_wrap (full_wrap),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata)
);

// File: tb/tb_csec_stopwatch.sv
`timescale 1ns/1ps
module tb_csec_stopwatch;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tb_pulse = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [3:0] bus_wdata = 4'd0;
    logic [3:0] bus_rdata;
    logic       irq_req;

    int  n_chk = 0;
    int  n_bad = 0;
    int  npul = 0;
    bit  model_en = 0;
    bit  done = 0;

    always #4 clk = ~clk;

    csec_stopwatch dut (
        .clk       (clk),
        .rst       (rst),
        .tb_pulse  (tb_pulse),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_req   (irq_req)
    );

    function automatic int tk(int n);
        return (n * 100) / 512;
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_pulses(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tb_pulse = 1'b1;
            @(negedge clk) tb_pulse = 1'b0;
            if (model_en) npul++;
        end
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [3:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_rd = 1'b1;
        #2 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [3:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_wdata = d;
        bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic chk_count(string tag);
        logic [3:0] t;
        logic [3:0] h;
        int e;
        e = tk(npul) % 100;
        rd_reg(2'd1, t);
        rd_reg(2'd0, h);
        chk({tag, " tenths"}, int'(t), e / 10);
        chk({tag, " hundredths"}, int'(h), e % 10);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [3:0] d;
        logic [3:0] t;
        logic [3:0] h;
        int prev_obs;
        int last_i;
        int fives;
        int sixes;
        bit exp_irq;
        int guard;

        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R9: reset state
        #2 chk("R9 rdata idle", int'(bus_rdata), 0);
        chk("R9 irq_req", int'(irq_req), 0);
        for (int a = 0; a < 4; a++) begin
            rd_reg(a[1:0], d);
            chk("R9 reg after reset", int'(d), 0);
        end

        // R1: enable bit readback
        wr_reg(2'd2, 4'h1);
        model_en = 1;
        rd_reg(2'd2, d);
        chk("R1 enable readback", int'(d), 1);

        // R2 R4 R7: full divider period sweep
        wr_reg(2'd0, 4'h0);
        npul = 0;
        prev_obs = 0;
        last_i = 0;
        fives = 0;
        sixes = 0;
        exp_irq = 0;
        for (int i = 1; i <= 512; i++) begin
            int obs;
            do_pulses(1);
            rd_reg(2'd1, t);
            rd_reg(2'd0, h);
            obs = int'(t) * 10 + int'(h);
            chk("R2 R4 count in sweep", obs, tk(i) % 100);
            if (obs != prev_obs) begin
                if (i - last_i == 5) fives++;
                else if (i - last_i == 6) sixes++;
                last_i = i;
                prev_obs = obs;
            end
            if ((tk(i) / 10) != (tk(i - 1) / 10)) exp_irq = 1;
            chk("R7 irq on carry", int'(irq_req), int'(exp_irq));
            if (exp_irq) begin
                wr_reg(2'd3, 4'h0);
                exp_irq = 0;
                chk("R8 irq cleared by write", int'(irq_req), 0);
            end
        end
        chk("R2 five-pulse gaps", fives, 88);
        chk("R2 six-pulse gaps", sixes, 12);
        chk("R4 tenths wrapped silently", obs_zero(prev_obs), 1);

        // R1: freeze keeps phase
        wr_reg(2'd0, 4'h3);
        npul = 0;
        do_pulses(3);
        wr_reg(2'd2, 4'h0);
        model_en = 0;
        do_pulses(10);
        chk_count("R1 frozen");
        rd_reg(2'd2, d);
        chk("R1 enable cleared", int'(d), 0);
        wr_reg(2'd2, 4'h1);
        model_en = 1;
        do_pulses(2);
        chk_count("R1 resume before tick");
        do_pulses(1);
        chk_count("R1 resume tick on 6th");
        chk("R1 phase kept", tk(npul), 1);

        // R5: clear through tenths address with nonzero data, holding register cleared
        do_pulses(40);
        rd_reg(2'd1, t);
        wr_reg(2'd1, 4'hF);
        npul = 0;
        rd_reg(2'd0, h);
        chk("R5 holding register cleared", int'(h), 0);
        chk_count("R5 cleared via tenths");
        // R5: divider phase reset by clear
        do_pulses(4);
        wr_reg(2'd0, 4'h5);
        npul = 0;
        do_pulses(5);
        chk_count("R5 no tick before 6th");
        do_pulses(1);
        chk_count("R5 tick on 6th after clear");

        // R6: snapshot on tenths read
        wr_reg(2'd0, 4'h0);
        npul = 0;
        do_pulses(190);
        rd_reg(2'd1, t);
        chk("R6 tenths read", int'(t), 3);
        do_pulses(10);
        rd_reg(2'd0, h);
        chk("R6 hundredths returns snapshot", int'(h), 7);
        chk_count("R6 fresh pair");

        // R8: set wins over a clearing write
        wr_reg(2'd3, 4'h0);
        chk("R8 irq low before", int'(irq_req), 0);
        guard = 0;
        while (!((tk(npul + 1) > tk(npul)) && (tk(npul) % 10 == 9)) && guard < 100) begin
            do_pulses(1);
            guard++;
        end
        @(negedge clk);
        tb_pulse = 1'b1;
        bus_addr = 2'd3;
        bus_wdata = 4'h0;
        bus_wr = 1'b1;
        @(negedge clk);
        tb_pulse = 1'b0;
        bus_wr = 1'b0;
        npul++;
        chk("R8 set wins over clear", int'(irq_req), 1);
        rd_reg(2'd3, d);
        chk("R7 flag at bit 3", int'(d), 8);
        wr_reg(2'd3, 4'h8);
        chk("R8 write bit3=1 keeps flag", int'(irq_req), 1);
        wr_reg(2'd3, 4'h7);
        chk("R8 write bit3=0 clears flag", int'(irq_req), 0);
        chk_count("R3 digits after carry");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    function automatic int obs_zero(int v);
        return (v == 0) ? 1 : 0;
    endfunction

endmodule